// File: doc/BRIEF.md
# Compact 32-bit Machine Timer

This block is a machine timer for a small processor system. A 32-bit time counter advances once per prescaler period, and a 32-bit compare register sets the point at which a level timer interrupt is raised. The prescaler period is programmed through a divider register. The two lowest bits of the divider are fixed at one, so the period is always a multiple of four system clocks. With a suitable divider the counter ticks at a nominal 1 MHz.

The interrupt test is wrap-aware. The unsigned difference counter minus compare is taken modulo 2^32. The interrupt is asserted while the top two bits of that difference are zero, which means the counter is at or past the compare value by less than 2^30 ticks. This keeps the interrupt correct when the counter wraps past zero. Software clears the interrupt by moving the compare value ahead of the counter.

All three registers sit behind a simple synchronous register port. Read data returns one cycle after the read. Writing the counter also restarts the prescaler phase, so the first tick after a write arrives a full period later.

Top module: `lite_mtimer`

## Requirements
- R1: Synchronous reset (rst high at a clock edge) sets the counter to 0 and the compare register to 0, and makes the divider read back as 3. timer_irq is 0 while rst is high.
- R2: Register selection uses bus_addr: 0 is the divider, 1 is the counter, 2 is the compare register. The divider stores bus_wdata[12:0] with bits 1:0 forced to 1, and it reads zero-extended to 32 bits.
- R3: With divider value d, the counter increments by one every d+1 clocks and wraps from 0xFFFFFFFF to 0.
- R4: The counter is read/write. A write loads bus_wdata, and the written value reads back on the next cycle.
- R5: The compare register is read/write, with 32 bits of storage.
- R6: timer_irq is 1 exactly when (counter - compare) mod 2^32 has bits 31:30 both zero. The output is registered, so it reflects the register values of the previous cycle.
- R7: The interrupt is a level signal. It drops one cycle after the compare register is written to a value ahead of the counter.
- R8: A counter write restarts the prescaler phase, so the next increment comes d+1 clocks after the write.
- R9: A read (bus_sel=1, bus_we=0) presents the selected register on bus_rdata in the following cycle. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| timer_irq | output | 1 | Level timer interrupt |

## Verification
A register write takes effect at the clock edge that samples it. Read data appears one cycle after the read edge, so a read issued k idle cycles after a counter write of X must return X + floor(k/(d+1)). The interrupt is registered on top of the register state, so it is checked two falling edges after the write that changed the counter or compare value. A large divider keeps the counter still during those checks. The scoreboard pushes each expected read value before the read is driven, and the monitor pops and compares it at the falling edge after the read edge.

// File: rtl/lmt_pkg.sv
package lmt_pkg;
  typedef enum logic [1:0] {
    SEL_DIV  = 2'd0,
    SEL_TIME = 2'd1,
    SEL_CMP  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/lmt_prescaler.sv
module lmt_prescaler #(
  parameter int DIV_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_wdata,
  input  logic             restart,
  output logic [DIV_W-1:0] div_q,
  output logic             tick
);
  localparam logic [DIV_W-1:0] FORCED = DIV_W'(3);

  logic [DIV_W-1:0] phase_q;
  logic             wrap;

  assign wrap = (phase_q >= div_q);
  assign tick = wrap && !restart;

  always_ff @(posedge clk) begin
    if (rst) div_q <= FORCED;
    else if (div_wr) div_q <= div_wdata | FORCED;
  end

  always_ff @(posedge clk) begin
    if (rst || restart) phase_q <= '0;
    else if (wrap) phase_q <= '0;
    else phase_q <= phase_q + 1'b1;
  end

  // R8
  phase_restart_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (phase_q == '0));
endmodule

// File: rtl/lmt_counter.sv
module lmt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             tick,
  output logic [CNT_W-1:0] mtime_q
);
  always_ff @(posedge clk) begin
    if (rst) mtime_q <= '0;
    else if (wr) mtime_q <= wdata;
    else if (tick) mtime_q <= mtime_q + 1'b1;
  end

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr) |=> (mtime_q == $past(mtime_q) + 1'b1));
  // R3
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr) |=> $stable(mtime_q));
  // R4
  count_load_chk: assert property (@(posedge clk) disable iff (rst)
    wr |=> (mtime_q == $past(wdata)));
endmodule

// File: rtl/lmt_compare.sv
module lmt_compare #(
  parameter int CNT_W      = 32,
  parameter int GUARD_BITS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic [CNT_W-1:0] mtime,
  output logic [CNT_W-1:0] cmp_q,
  output logic             irq_q
);
  logic [CNT_W-1:0] diff;
  logic             in_win;

  assign diff = mtime - cmp_q;

  generate
    if (GUARD_BITS > 0) begin : g_win
      assign in_win = ~|diff[CNT_W-1 -: GUARD_BITS];
    end else begin : g_all
      assign in_win = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) cmp_q <= '0;
    else if (cmp_wr) cmp_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else irq_q <= in_win;
  end

  // R5
  cmp_load_chk: assert property (@(posedge clk) disable iff (rst)
    cmp_wr |=> (cmp_q == $past(wdata)));
  // R6
  irq_window_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (irq_q == ($past(mtime - cmp_q) < (CNT_W'(1) << (CNT_W - GUARD_BITS)))));
endmodule

// File: rtl/lmt_regbus.sv
module lmt_regbus #(
  parameter int CNT_W = 32,
  parameter int DIV_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [DIV_W-1:0] div_q,
  input  logic [CNT_W-1:0] mtime,
  input  logic [CNT_W-1:0] cmp,
  output logic             div_wr,
  output logic             time_wr,
  output logic             cmp_wr,
  output logic [CNT_W-1:0] rdata_q
);
  import lmt_pkg::*;

  reg_sel_e         which;
  logic [CNT_W-1:0] rmux;

  assign which   = reg_sel_e'(addr);
  assign div_wr  = sel && we && (which == SEL_DIV);
  assign time_wr = sel && we && (which == SEL_TIME);
  assign cmp_wr  = sel && we && (which == SEL_CMP);

  always_comb begin
    case (which)
      SEL_DIV:  rmux = CNT_W'(div_q);
      SEL_TIME: rmux = mtime;
      SEL_CMP:  rmux = cmp;
      default:  rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (sel && !we) rdata_q <= rmux;
  end

  // R9
  one_write_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({div_wr, time_wr, cmp_wr}));
  // R2
  div_read_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (sel && !we && which == SEL_DIV) |=> (rdata_q[1:0] == 2'b11));
endmodule

// File: rtl/lite_mtimer.sv
module lite_mtimer #(
  parameter int CNT_W      = 32,
  parameter int DIV_W      = 13,
  parameter int GUARD_BITS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             timer_irq
);
  logic             div_wr, time_wr, cmp_wr, tick;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] mtime, cmp;

  lmt_regbus #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_bus (
    .clk(clk), .rst(rst), .sel(bus_sel), .we(bus_we), .addr(bus_addr),
    .div_q(div_q), .mtime(mtime), .cmp(cmp),
    .div_wr(div_wr), .time_wr(time_wr), .cmp_wr(cmp_wr), .rdata_q(bus_rdata)
  );

  lmt_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst(rst), .div_wr(div_wr), .div_wdata(bus_wdata[DIV_W-1:0]),
    .restart(time_wr), .div_q(div_q), .tick(tick)
  );

  lmt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .wr(time_wr), .wdata(bus_wdata), .tick(tick),
    .mtime_q(mtime)
  );

  lmt_compare #(.CNT_W(CNT_W), .GUARD_BITS(GUARD_BITS)) u_cmp (
    .clk(clk), .rst(rst), .cmp_wr(cmp_wr), .wdata(bus_wdata), .mtime(mtime),
    .cmp_q(cmp), .irq_q(timer_irq)
  );

  // R1
  reset_irq_chk: assert property (@(posedge clk)
    rst |=> !timer_irq);
endmodule

// File: tb/lite_mtimer_test.sv
module lite_mtimer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        timer_irq;

  int total = 0, bad = 0;
  bit done = 0;
  logic rd_seen = 1'b0;

  typedef struct { logic [31:0] exp; string tag; } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  lite_mtimer uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .timer_irq(timer_irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(logic [1:0] a, logic [31:0] exp, string tag);
    exp_t e;
    e.exp = exp; e.tag = tag;
    sb.push_back(e);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // irq reflects register state after one more edge
  task automatic irq_chk(string tag, logic exp);
    idle(1);
    chk(tag, {31'd0, timer_irq}, {31'd0, exp});
  endtask

  always @(posedge clk) rd_seen <= bus_sel && !bus_we;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (sb.size() == 0) begin
        total++; bad++;
        $display("FAIL R9 unexpected read actual=%h expected=none", bus_rdata);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, bus_rdata, e.exp);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 irq low in reset", {31'd0, timer_irq}, 32'd0);
    rst = 0;
    rd(2'd0, 32'd3, "R1 div reset");
    rd(2'd1, 32'd0, "R1 time reset");
    rd(2'd2, 32'd0, "R1 cmp reset");
    rd(2'd3, 32'd0, "R9 unmapped addr");
    // counter 0 == cmp 0 -> in window (R6)
    chk("R6 irq at equal after reset", {31'd0, timer_irq}, 32'd1);

    wr(2'd0, 32'd0);           rd(2'd0, 32'd3,    "R2 forced low bits");
    wr(2'd0, 32'h10);          rd(2'd0, 32'h13,   "R2 div 0x10");
    wr(2'd0, 32'hFFFF_FFFF);   rd(2'd0, 32'h1FFF, "R2 div width");

    wr(2'd2, 32'hCAFE_F00D);   rd(2'd2, 32'hCAFE_F00D, "R5 cmp readback");

    // rate, d=3
    wr(2'd0, 32'd3);
    wr(2'd1, 32'd100); rd(2'd1, 32'd100, "R4 time readback");
    wr(2'd1, 32'd100); idle(10); rd(2'd1, 32'd102, "R3 d=3 ten cycles");
    wr(2'd0, 32'd7);
    wr(2'd1, 32'd500); idle(20); rd(2'd1, 32'd502, "R3 d=7 twenty cycles");
    wr(2'd0, 32'd3);
    wr(2'd1, 32'hFFFF_FFFF); idle(4); rd(2'd1, 32'd0, "R3 wrap to zero");

    // phase restart
    wr(2'd1, 32'd40); idle(2);
    wr(2'd1, 32'd900); idle(3); rd(2'd1, 32'd900, "R8 phase restart");

    // irq window with a frozen counter
    wr(2'd0, 32'h1FFF);
    wr(2'd2, 32'd1000); wr(2'd1, 32'd1000);       irq_chk("R6 equal", 1'b1);
    wr(2'd1, 32'd999);                            irq_chk("R6 one before", 1'b0);
    wr(2'd1, 32'd1000 + 32'h3FFF_FFFF);           irq_chk("R6 window edge in", 1'b1);
    wr(2'd1, 32'd1000 + 32'h4000_0000);           irq_chk("R6 window edge out", 1'b0);
    wr(2'd2, 32'hFFFF_FFF0); wr(2'd1, 32'h10);    irq_chk("R6 wrap in window", 1'b1);
    wr(2'd1, 32'h7FFF_FFF0);                      irq_chk("R6 half way out", 1'b0);

    // level clear by moving compare ahead
    wr(2'd2, 32'd5); wr(2'd1, 32'd5);             irq_chk("R7 set", 1'b1);
    wr(2'd2, 32'd6);                              irq_chk("R7 cleared", 1'b0);

    // dynamic crossing with d=3
    wr(2'd0, 32'd3);
    wr(2'd2, 32'd51); wr(2'd1, 32'd50);           irq_chk("R6 before tick", 1'b0);
    idle(6);
    chk("R6 after tick", {31'd0, timer_irq}, 32'd1);

    idle(2);
    chk("R9 scoreboard drained", sb.size(), 32'd0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule